// File: doc/BRIEF.md
# Masked associative search engine

This block is a small content-addressable memory. A host issues one command per clock on a single command port. Commands write words into entries, change the tag of an entry, load the comparand or the global mask, program the search configuration, force a search, rotate the comparand and swap between two configuration contexts. Every entry holds a data word and a two-bit tag. Searches compare the comparand against all entries whose tag equals the requested type, in parallel and in one clock.

Each word is divided into a searched part and an unsearched associated-data part. The split is made on segment boundaries, and the searched part sits at either end of the word. The mask can turn any comparand bit into a don't-care for searches. The same mask can also protect bits of an entry during writes.

The block reports the following results:
- a hit flag and a multiple-hit flag;
- the lowest matching entry number;
- a full flag;
- the lowest free entry number.

Top module: `masked_cam`

## Requirements
- R1: Tags are encoded as 00 Empty, 01 Valid, 10 Skip, 11 RAM. After reset:
  - every entry is 0 and tagged Empty;
  - comparand and mask are 0;
  - both contexts hold the default configuration (full-width search, no masking);
  - context 0 is active;
  - hit, multiple hit and hit address are 0.
- R2: Loading the comparand, loading the mask or writing the configuration starts an automatic search. The search uses the newly loaded value and considers only entries tagged Valid.
- R3: A forced search compares the current comparand only against entries whose tag equals `op_tag`.
- R4: When compare masking is enabled, a mask bit of 1 makes that comparand bit a don't-care for every entry.
- R5: The searched part is (cam_segs+1) segments of 16 bits. It starts at bit 0 when ram_low is 0 and ends at the top bit when ram_low is 1. Bits outside it never affect a search.
- R6: With one or more hits, `hit_addr` is the lowest matching entry. `multi_hit` is 1 only with two or more hits.
- R7: With no hit, `hit` is 0 and `hit_addr` is 0.
- R8: Search results appear on the clock edge that accepts the search command. All other commands except a context swap leave them unchanged.
- R9: A context swap clears hit, multiple hit and hit address. Each context keeps its own configuration, and configuration writes go to the active context.
- R10: `full` is 1 exactly when no entry is tagged Empty. `free_addr` is the lowest Empty entry, or 0 when full.
- R11: A write stores `op_data` and `op_tag` into entry `op_addr`. When write masking is enabled, each entry bit whose mask bit is 1 keeps its old value. Setting a tag changes only the tag.
- R12: Rotate-left moves comparand bit i to bit i+1, with the top bit going to bit 0. Rotate-right moves bits the other way. A rotation starts no search.
- R13: Command codes: 0 none, 1 write, 2 set tag, 3 load comparand, 4 load mask, 5 configure, 6 forced search, 7 rotate left, 8 rotate right, 9 context swap. Configuration fields in `op_data` are:
  - bit 0: compare mask enable;
  - bit 1: write mask enable;
  - bits 3:2: cam_segs;
  - bit 4: ram_low.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Synchronous active-low reset |
| op_valid | input | 1 | Command strobe |
| op_code | input | 4 | Command code |
| op_addr | input | 4 | Entry number for write and set-tag |
| op_tag | input | 2 | Tag for write, set-tag and forced search |
| op_data | input | 64 | Data, comparand, mask or configuration |
| rd_addr | input | 4 | Entry number for the read port |
| rd_word | output | 64 | Word stored at `rd_addr` |
| rd_tag | output | 2 | Tag stored at `rd_addr` |
| cmp_word | output | 64 | Current comparand |
| hit | output | 1 | At least one entry matched |
| multi_hit | output | 1 | Two or more entries matched |
| hit_addr | output | 4 | Lowest matching entry |
| full | output | 1 | No Empty entry remains |
| free_addr | output | 4 | Lowest Empty entry |

## Verification
The assertions check several relations on every cycle:
- a multiple hit implies a hit;
- a miss always reports address 0;
- a context swap leaves the results cleared;
- results hold between searches;
- a tag write lands;
- the priority pick is a set bit with no lower set bit.

Only the bench scenarios can show that the hit vector itself is correct. That covers tag selection per search, masked and partial-width comparison at either end of the word, protected write bits, and per-context configuration. The bench checks these against a reference model over directed cases and a long seeded random run.

// File: rtl/cam_pkg.sv
// Shared types for the masked associative search engine.
// Assumes the word holds at most four search segments (two-bit segment count).
package cam_pkg;

    typedef enum logic [1:0] {
        TAG_EMPTY = 2'b00,
        TAG_VALID = 2'b01,
        TAG_SKIP  = 2'b10,
        TAG_RAM   = 2'b11
    } tag_e;

    typedef enum logic [3:0] {
        OP_NOP   = 4'd0,
        OP_WRITE = 4'd1,
        OP_STAG  = 4'd2,
        OP_LDCMP = 4'd3,
        OP_LDMSK = 4'd4,
        OP_CFG   = 4'd5,
        OP_FORCE = 4'd6,
        OP_ROTL  = 4'd7,
        OP_ROTR  = 4'd8,
        OP_SWAP  = 4'd9
    } op_e;

    // Search configuration; packed so bit 0 is cmp_mask_en and bit 4 is ram_low.
    typedef struct packed {
        logic       ram_low;
        logic [1:0] cam_segs;
        logic       wr_mask_en;
        logic       cmp_mask_en;
    } cfg_t;

endpackage

// File: rtl/cam_prienc.sv
// Lowest-index priority picker.
// Reports whether any bit is set, whether two or more are set, and the index
// of the lowest set bit (0 when none). Purely combinational.
module cam_prienc #(
    parameter int N = 16
) (
    input  logic [N-1:0]                    vec,
    output logic                            any,
    output logic                            multi,
    output logic [((N > 1) ? $clog2(N) : 1)-1:0] idx
);
    localparam int IW = (N > 1) ? $clog2(N) : 1;

    // Scan from the top so the lowest set bit wins.
    always_comb begin
        idx = '0;
        for (int i = N - 1; i >= 0; i--) begin
            if (vec[i]) idx = IW'(i);
        end
    end

    // Any and multiple flags; clearing the lowest set bit leaves others.
    assign any   = |vec;
    assign multi = |(vec & (vec - N'(1)));

    // Picked index must be set and have no lower set bit.
    always_comb begin
        if (any) begin
            AST_PICK_IS_SET: assert (vec[idx]) else $error("pick not set"); // R6
            AST_PICK_IS_LOWEST: assert ((vec & ~({N{1'b1}} << idx)) == '0) else $error("pick not lowest"); // R6
        end
    end

endmodule

// File: rtl/cam_store.sv
// Entry storage with tags, masked writes, a read port and the parallel
// match vector. Assumes write and set-tag never occur in the same cycle.
module cam_store
    import cam_pkg::*;
#(
    parameter int ENTRIES = 16,
    parameter int WORD_W  = 64
) (
    input  logic                       clk,
    input  logic                       rst_n,
    input  logic                       wr_en,
    input  logic                       tag_en,
    input  logic [$clog2(ENTRIES)-1:0] wr_addr,
    input  logic [WORD_W-1:0]          wr_data,
    input  logic [WORD_W-1:0]          wr_keep,
    input  tag_e                       wr_tag,
    input  logic [WORD_W-1:0]          key,
    input  logic [WORD_W-1:0]          care,
    input  tag_e                       target,
    input  logic [$clog2(ENTRIES)-1:0] rd_addr,
    output logic [ENTRIES-1:0]         match_vec,
    output logic [ENTRIES-1:0]         empty_vec,
    output logic [WORD_W-1:0]          rd_word,
    output tag_e                       rd_tag
);
    logic [WORD_W-1:0] mem_q [ENTRIES];
    tag_e              tag_q [ENTRIES];

    // Entry and tag update, with protected bits kept on writes.
    always_ff @(posedge clk) begin
        if (!rst_n) begin
            for (int i = 0; i < ENTRIES; i++) begin
                mem_q[i] <= '0;
                tag_q[i] <= TAG_EMPTY;
            end
        end else if (wr_en) begin
            mem_q[wr_addr] <= (mem_q[wr_addr] & wr_keep) | (wr_data & ~wr_keep);
            tag_q[wr_addr] <= wr_tag;
        end else if (tag_en) begin
            tag_q[wr_addr] <= wr_tag;
        end
    end

    // Per-entry compare and empty detection.
    for (genvar g = 0; g < ENTRIES; g++) begin : g_entry
        assign match_vec[g] = (tag_q[g] == target) && (((mem_q[g] ^ key) & care) == '0);
        assign empty_vec[g] = (tag_q[g] == TAG_EMPTY);
    end

    // Read port.
    assign rd_word = mem_q[rd_addr];
    assign rd_tag  = tag_q[rd_addr];

    AST_TAG_LANDS: assert property (@(posedge clk) disable iff (!rst_n)
        $past(wr_en || tag_en) |-> tag_q[$past(wr_addr)] == $past(wr_tag))
        else $error("tag write lost"); // R11

endmodule

// File: rtl/masked_cam.sv
// Masked associative search engine top.
// Decodes one command per clock, holds comparand, mask and two configuration
// contexts, builds the search care mask and registers search results.
// Assumes WORD_W is SEG_W times at most four segments.
module masked_cam
    import cam_pkg::*;
#(
    parameter int ENTRIES = 16,
    parameter int WORD_W  = 64,
    parameter int SEG_W   = 16
) (
    input  logic                       clk,
    input  logic                       rst_n,
    input  logic                       op_valid,
    input  logic [3:0]                 op_code,
    input  logic [$clog2(ENTRIES)-1:0] op_addr,
    input  logic [1:0]                 op_tag,
    input  logic [WORD_W-1:0]          op_data,
    input  logic [$clog2(ENTRIES)-1:0] rd_addr,
    output logic [WORD_W-1:0]          rd_word,
    output logic [1:0]                 rd_tag,
    output logic [WORD_W-1:0]          cmp_word,
    output logic                       hit,
    output logic                       multi_hit,
    output logic [$clog2(ENTRIES)-1:0] hit_addr,
    output logic                       full,
    output logic [$clog2(ENTRIES)-1:0] free_addr
);
    localparam int   AW      = $clog2(ENTRIES);
    localparam int   NSEG    = WORD_W / SEG_W;
    localparam cfg_t CFG_RST = '{ram_low: 1'b0, cam_segs: 2'(NSEG - 1),
                                 wr_mask_en: 1'b0, cmp_mask_en: 1'b0};

    op_e               op;
    logic              is_wr, is_tag, is_ldc, is_ldm, is_cfg, is_frc, is_rl, is_rr, is_swap;
    logic              do_cmp;
    logic [WORD_W-1:0] cmp_q, mask_q;
    cfg_t              cfg_q [2];
    logic              ctx_q;
    cfg_t              cfg_act, cfg_use;
    logic [WORD_W-1:0] key_use, mask_use, region, care;
    logic [NSEG-1:0]   seg_on;
    tag_e              target;
    logic [ENTRIES-1:0] match_vec, empty_vec;
    logic              m_any, m_multi, f_any, f_multi;
    logic [AW-1:0]     m_idx, f_idx;
    logic              hit_q, multi_q;
    logic [AW-1:0]     addr_q;
    tag_e              rd_tag_e;

    assign op = op_e'(op_code);

    // Command decode, each flag qualified by the strobe.
    always_comb begin
        is_wr   = op_valid && (op == OP_WRITE);
        is_tag  = op_valid && (op == OP_STAG);
        is_ldc  = op_valid && (op == OP_LDCMP);
        is_ldm  = op_valid && (op == OP_LDMSK);
        is_cfg  = op_valid && (op == OP_CFG);
        is_frc  = op_valid && (op == OP_FORCE);
        is_rl   = op_valid && (op == OP_ROTL);
        is_rr   = op_valid && (op == OP_ROTR);
        is_swap = op_valid && (op == OP_SWAP);
    end

    assign do_cmp  = is_ldc || is_ldm || is_cfg || is_frc;
    assign cfg_act = cfg_q[ctx_q];

    // Search operands: newly loaded values take effect in the same search.
    always_comb begin
        key_use  = is_ldc ? op_data : cmp_q;
        mask_use = is_ldm ? op_data : mask_q;
        cfg_use  = is_cfg ? cfg_t'(op_data[4:0]) : cfg_act;
        target   = is_frc ? tag_e'(op_tag) : TAG_VALID;
    end

    // Which segments belong to the searched part.
    always_comb begin
        for (int s = 0; s < NSEG; s++) begin
            seg_on[s] = cfg_use.ram_low ? ((s + int'(cfg_use.cam_segs)) >= (NSEG - 1))
                                        : (s <= int'(cfg_use.cam_segs));
        end
    end

    for (genvar s = 0; s < NSEG; s++) begin : g_region
        assign region[s*SEG_W +: SEG_W] = {SEG_W{seg_on[s]}};
    end

    assign care = region & ~(mask_use & {WORD_W{cfg_use.cmp_mask_en}});

    cam_store #(.ENTRIES(ENTRIES), .WORD_W(WORD_W)) u_store (
        .clk       (clk),
        .rst_n     (rst_n),
        .wr_en     (is_wr),
        .tag_en    (is_tag),
        .wr_addr   (op_addr),
        .wr_data   (op_data),
        .wr_keep   (mask_q & {WORD_W{cfg_act.wr_mask_en}}),
        .wr_tag    (tag_e'(op_tag)),
        .key       (key_use),
        .care      (care),
        .target    (target),
        .rd_addr   (rd_addr),
        .match_vec (match_vec),
        .empty_vec (empty_vec),
        .rd_word   (rd_word),
        .rd_tag    (rd_tag_e)
    );

    cam_prienc #(.N(ENTRIES)) u_match_pick (
        .vec (match_vec), .any (m_any), .multi (m_multi), .idx (m_idx)
    );

    cam_prienc #(.N(ENTRIES)) u_free_pick (
        .vec (empty_vec), .any (f_any), .multi (f_multi), .idx (f_idx)
    );

    // Comparand and mask registers, including one-bit rotations.
    always_ff @(posedge clk) begin
        if (!rst_n) begin
            cmp_q  <= '0;
            mask_q <= '0;
        end else begin
            if (is_ldc)     cmp_q <= op_data;
            else if (is_rl) cmp_q <= {cmp_q[WORD_W-2:0], cmp_q[WORD_W-1]};
            else if (is_rr) cmp_q <= {cmp_q[0], cmp_q[WORD_W-1:1]};
            if (is_ldm)     mask_q <= op_data;
        end
    end

    // Two configuration contexts and the active-context selector.
    always_ff @(posedge clk) begin
        if (!rst_n) begin
            cfg_q[0] <= CFG_RST;
            cfg_q[1] <= CFG_RST;
            ctx_q    <= 1'b0;
        end else begin
            if (is_cfg)  cfg_q[ctx_q] <= cfg_t'(op_data[4:0]);
            if (is_swap) ctx_q <= ~ctx_q;
        end
    end

    // Registered search results; cleared by a context swap.
    always_ff @(posedge clk) begin
        if (!rst_n || is_swap) begin
            hit_q   <= 1'b0;
            multi_q <= 1'b0;
            addr_q  <= '0;
        end else if (do_cmp) begin
            hit_q   <= m_any;
            multi_q <= m_multi;
            addr_q  <= m_any ? m_idx : '0;
        end
    end

    assign hit       = hit_q;
    assign multi_hit = multi_q;
    assign hit_addr  = addr_q;
    assign full      = ~f_any;
    assign free_addr = f_idx;
    assign cmp_word  = cmp_q;
    assign rd_tag    = rd_tag_e;

    AST_MULTI_NEEDS_HIT: assert property (@(posedge clk) disable iff (!rst_n)
        multi_hit |-> hit) else $error("multi without hit"); // R6
    AST_MISS_ADDR_ZERO: assert property (@(posedge clk) disable iff (!rst_n)
        !hit |-> (hit_addr == '0)) else $error("miss with address"); // R7
    AST_SWAP_CLEARS: assert property (@(posedge clk) disable iff (!rst_n)
        $past(is_swap) |-> (!hit && !multi_hit && hit_addr == '0)) else $error("swap kept result"); // R9
    AST_RESULT_HOLDS: assert property (@(posedge clk) disable iff (!rst_n)
        !$past(do_cmp || is_swap) |-> ($stable(hit) && $stable(multi_hit) && $stable(hit_addr)))
        else $error("result moved"); // R8
    AST_FULL_NO_FREE: assert property (@(posedge clk) disable iff (!rst_n)
        full |-> (free_addr == '0 && !f_multi)) else $error("full with free slot"); // R10

endmodule

// File: tb/masked_cam_tb.sv
module masked_cam_tb;
    localparam int CLK_PERIOD = 10;

    // Command codes per R13.
    localparam logic [3:0] C_WR = 4'd1, C_TAG = 4'd2, C_LDC = 4'd3, C_LDM = 4'd4,
                           C_CFG = 4'd5, C_FRC = 4'd6, C_RL = 4'd7, C_RR = 4'd8, C_SWAP = 4'd9;
    localparam logic [1:0] T_EMPTY = 2'b00, T_VALID = 2'b01, T_SKIP = 2'b10, T_RAM = 2'b11;

    logic        clk = 1'b0;
    logic        rst_n = 1'b0;
    logic        op_valid = 1'b0;
    logic [3:0]  op_code = '0;
    logic [3:0]  op_addr = '0;
    logic [1:0]  op_tag = '0;
    logic [63:0] op_data = '0;
    logic [3:0]  rd_addr = '0;
    logic [63:0] rd_word, cmp_word;
    logic [1:0]  rd_tag;
    logic        hit, multi_hit, full;
    logic [3:0]  hit_addr, free_addr;

    int n_chk = 0;
    int n_fail = 0;

    // Reference model state.
    logic [63:0] m_mem [16];
    logic [1:0]  m_tag [16];
    logic [63:0] m_cmp, m_mask;
    logic [4:0]  m_cfg [2];
    logic        m_ctx, m_hit, m_multi;
    logic [3:0]  m_addr;

    always #(CLK_PERIOD / 2) clk = ~clk;

    masked_cam u_dut (
        .clk (clk), .rst_n (rst_n), .op_valid (op_valid), .op_code (op_code),
        .op_addr (op_addr), .op_tag (op_tag), .op_data (op_data), .rd_addr (rd_addr),
        .rd_word (rd_word), .rd_tag (rd_tag), .cmp_word (cmp_word), .hit (hit),
        .multi_hit (multi_hit), .hit_addr (hit_addr), .full (full), .free_addr (free_addr)
    );

    // Searched bits per R4 and R5.
    function automatic logic [63:0] f_care(logic [4:0] c, logic [63:0] mk);
        logic [63:0] r = '0;
        for (int s = 0; s < 4; s++) begin
            if (c[4] ? ((s + int'(c[3:2])) >= 3) : (s <= int'(c[3:2])))
                r[s*16 +: 16] = 16'hFFFF;
        end
        return r & ~(c[0] ? mk : 64'h0);
    endfunction

    // Search model per R2, R3, R6 and R7.
    task automatic m_search(logic [63:0] key, logic [63:0] mk, logic [4:0] c, logic [1:0] tg);
        int cnt = 0;
        logic [3:0] a = '0;
        logic [63:0] cr = f_care(c, mk);
        for (int i = 15; i >= 0; i--) begin
            if (m_tag[i] == tg && ((m_mem[i] ^ key) & cr) == 64'h0) begin
                cnt++;
                a = 4'(i);
            end
        end
        m_hit = (cnt > 0);
        m_multi = (cnt > 1);
        m_addr = (cnt > 0) ? a : 4'h0;
    endtask

    task automatic chk(string rq, string what, logic [63:0] act, logic [63:0] exp);
        n_chk++;
        if (act !== exp) begin
            n_fail++;
            $display("FAIL %s %s: actual %h expected %h", rq, what, act, exp);
        end
    endtask

    task automatic check_all(string rq, logic [3:0] a);
        logic [3:0] fr = '0;
        logic anyf = 1'b0;
        for (int i = 15; i >= 0; i--) begin
            if (m_tag[i] == T_EMPTY) begin
                anyf = 1'b1;
                fr = 4'(i);
            end
        end
        rd_addr = a;
        #1;
        chk(rq, "hit", 64'(hit), 64'(m_hit));
        chk("R6", "multi_hit", 64'(multi_hit), 64'(m_multi));
        chk(m_hit ? "R6" : "R7", "hit_addr", 64'(hit_addr), 64'(m_addr));
        chk("R10", "full", 64'(full), 64'(!anyf));
        chk("R10", "free_addr", 64'(free_addr), 64'(fr));
        chk("R12", "cmp_word", cmp_word, m_cmp);
        chk("R11", "rd_word", rd_word, m_mem[a]);
        chk("R1", "rd_tag", 64'(rd_tag), 64'(m_tag[a]));
    endtask

    // Drive one command at a falling edge, update the model, check after the edge.
    task automatic do_op(logic [3:0] code, logic [3:0] a, logic [1:0] tg, logic [63:0] d);
        string rq;
        logic [63:0] keep;
        op_valid = 1'b1; op_code = code; op_addr = a; op_tag = tg; op_data = d;
        @(negedge clk);
        op_valid = 1'b0; op_code = '0;
        rq = "R8";
        case (code)
            C_WR: begin
                keep = m_cfg[m_ctx][1] ? m_mask : 64'h0;
                m_mem[a] = (m_mem[a] & keep) | (d & ~keep);
                m_tag[a] = tg;
            end
            C_TAG:  m_tag[a] = tg;
            C_LDC:  begin m_cmp = d; m_search(m_cmp, m_mask, m_cfg[m_ctx], T_VALID); rq = "R2"; end
            C_LDM:  begin m_mask = d; m_search(m_cmp, m_mask, m_cfg[m_ctx], T_VALID); rq = "R4"; end
            C_CFG:  begin m_cfg[m_ctx] = d[4:0]; m_search(m_cmp, m_mask, m_cfg[m_ctx], T_VALID); rq = "R5"; end
            C_FRC:  begin m_search(m_cmp, m_mask, m_cfg[m_ctx], tg); rq = "R3"; end
            C_RL:   m_cmp = {m_cmp[62:0], m_cmp[63]};
            C_RR:   m_cmp = {m_cmp[0], m_cmp[63:1]};
            C_SWAP: begin m_ctx = ~m_ctx; m_hit = 0; m_multi = 0; m_addr = 0; rq = "R9"; end
            default: ;
        endcase
        check_all(rq, a);
    endtask

    function automatic logic [63:0] pick_data();
        logic [63:0] pool [4] = '{64'h1234_5678_9ABC_DEF0, 64'h0F0F_0F0F_0F0F_0F0F,
                                   64'hDEAD_BEEF_0000_FFFF, 64'h0};
        logic [63:0] v = pool[$urandom % 4];
        if ($urandom % 3 == 0) v[($urandom % 4) * 16 +: 16] = 16'($urandom);
        if ($urandom % 5 == 0) v = {$urandom, $urandom};
        return v;
    endfunction

    localparam logic [63:0] V = 64'h1234_5678_9ABC_DEF0;

    initial begin
        void'($urandom(32'd20240611));
        for (int i = 0; i < 16; i++) begin m_mem[i] = '0; m_tag[i] = T_EMPTY; end
        m_cmp = '0; m_mask = '0; m_cfg[0] = 5'b01100; m_cfg[1] = 5'b01100;
        m_ctx = 0; m_hit = 0; m_multi = 0; m_addr = 0;
        repeat (4) @(negedge clk);
        rst_n = 1'b1;
        check_all("R1", 4'd0);                       // R1 reset state
        do_op(C_WR, 0, T_VALID, 64'h1);
        do_op(C_WR, 1, T_VALID, 64'h2);
        do_op(C_WR, 2, T_VALID, V);
        do_op(C_WR, 3, T_VALID, V);
        do_op(C_LDC, 0, 0, V);                       // R6 two hits, lowest 2
        do_op(C_TAG, 2, T_SKIP, 0);                  // R11 tag only
        do_op(C_LDC, 0, 0, V);                       // R2 Skip entry ignored
        do_op(C_FRC, 0, T_SKIP, 0);                  // R3 forced on Skip
        do_op(C_FRC, 0, T_RAM, 0);                   // R7 no RAM entries
        do_op(C_LDM, 0, 0, 64'hFF);
        do_op(C_CFG, 0, 0, 64'h0D);                  // R4 compare mask on
        do_op(C_LDC, 0, 0, V ^ 64'h0F);              // R4 masked bits ignored
        do_op(C_CFG, 0, 0, 64'h00);                  // R5 low segment only
        do_op(C_LDC, 0, 0, V ^ 64'hFFFF_0000_0000_0000);
        do_op(C_CFG, 0, 0, 64'h10);                  // R5 top segment only
        do_op(C_LDC, 0, 0, {V[63:48], 48'h0});
        do_op(C_CFG, 0, 0, 64'h0E);                  // R11 write mask on
        do_op(C_WR, 1, T_VALID, '1);
        do_op(C_SWAP, 0, 0, 0);                      // R9 results cleared
        do_op(C_LDC, 0, 0, V);                       // R9 context 1 default config
        do_op(C_SWAP, 0, 0, 0);
        do_op(C_LDC, 0, 0, 64'h8000_0000_0000_0001);
        do_op(C_RL, 0, 0, 0);                        // R12 wrap top to bottom
        do_op(C_RR, 0, 0, 0);
        do_op(C_RR, 0, 0, 0);                        // R12 wrap bottom to top
        do_op(C_CFG, 0, 0, 64'h0C);
        for (int i = 0; i < 16; i++) do_op(C_WR, 4'(i), T_VALID, 64'(i));  // R10 fill
        do_op(C_TAG, 5, T_EMPTY, 0);                 // R10 free slot 5
        do_op(C_TAG, 5, T_RAM, 0);
        for (int n = 0; n < 4000; n++) begin
            logic [3:0] code;
            int r = $urandom % 20;
            if (r < 6)       code = C_WR;
            else if (r < 8)  code = C_TAG;
            else if (r < 12) code = C_LDC;
            else if (r < 13) code = C_LDM;
            else if (r < 14) code = C_CFG;
            else if (r < 16) code = C_FRC;
            else if (r < 17) code = C_RL;
            else if (r < 18) code = C_RR;
            else if (r < 19) code = C_SWAP;
            else             code = 4'd0;
            if (code == C_LDM)
                do_op(code, 4'($urandom), 2'($urandom), {$urandom, $urandom} & {$urandom, $urandom});
            else if (code == C_CFG)
                do_op(code, 4'($urandom), 2'($urandom), 64'($urandom % 32));
            else
                do_op(code, 4'($urandom), 2'($urandom), pick_data());
        end
        $display("End of test - %0d assertions evaluated, %0d failures", n_chk, n_fail);
        $finish;
    end

    initial begin
        #(CLK_PERIOD * 150000);
        n_fail++;
        $display("FAIL watchdog: actual timeout expected completion");
        $display("End of test - %0d assertions evaluated, %0d failures", n_chk, n_fail);
        $finish;
    end

endmodule